// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This unit sits on the bus side of a processor core and keeps a small byte queue filled with upcoming code. It holds a 16-bit code segment and a 16-bit instruction offset. From these it builds a 20-bit physical fetch address: the segment is shifted left by four bits and the offset is added, modulo 2^20. It then requests 16-bit words from a simple request/acknowledge memory port. When the offset is odd, only the upper byte lane is requested, so that later fetches run on even, word-aligned addresses.

The execution side removes one byte per cycle from the head of the queue. With each removal it says whether that byte starts an instruction. Every cycle the unit publishes a 2-bit code that describes what happened to the queue in the previous cycle. A flush input, raised for a jump, empties the queue and restarts fetching at a new segment:offset. Data from a memory response that arrives in the same cycle as the flush is thrown away.

Top module: `fetch_queue_unit`

## Requirements
- R1: After reset the queue is empty (`qValid`=0) and `qStatus`=00. The first fetch request targets `RESET_SEG`*16 + `RESET_OFF` (0xFFFF0 with the default parameters) as a word fetch.
- R2: `memAddr` during a request equals (segment << 4) + offset, truncated to 20 bits.
- R3: The lane pair {`memHighEnN`, `memAddr[0]`} reads 00 for a word fetch from an even address and 01 for an upper-byte-only fetch from an odd address. It reads 11 whenever no request is raised. The code 10 (lower byte only) is never produced.
- R4: A word fetch is requested only while at least 2 of the 6 byte slots are free, and an odd fetch only while at least 1 is free. The queue never holds more than 6 bytes.
- R5: After each acknowledged fetch the offset advances by 2 (word) or by 1 (odd upper byte), wrapping within 16 bits. The segment changes only on a flush.
- R6: Bytes leave the queue in ascending address order. For a word fetch the low lane `memRdata[7:0]` comes first and the high lane `memRdata[15:8]` second. For an odd fetch only `memRdata[15:8]` is used.
- R7: `qStatus` reports the previous cycle's queue operation: 00 when no byte was taken, 01 when a byte was taken with `takeFirst`=1, and 11 when a byte was taken with `takeFirst`=0.
- R8: A cycle with `flushReq`=1 yields `qStatus`=10 and an empty queue in the next cycle, and fetching resumes at `flushSeg`:`flushOff`. A take raised in the same cycle is not performed.
- R9: A memory acknowledge that arrives in the same cycle as `flushReq` writes nothing into the queue.
- R10: `memSegStat` reads 10 (code segment) while `memReq` is high and 00 otherwise.
- R11: A take raised while the queue is empty has no effect, and `qStatus` reports 00 for that cycle.
- R12: While `memReq` is high and not acknowledged, and no flush occurs, the request and its address stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushReq | input | 1 | Empty the queue and reload segment and offset |
| flushSeg | input | 16 | New code segment on flush |
| flushOff | input | 16 | New instruction offset on flush |
| takeReq | input | 1 | Remove the head byte this cycle |
| takeFirst | input | 1 | The byte being taken starts an instruction |
| qByte | output | 8 | Byte at the head of the queue |
| qValid | output | 1 | Queue holds at least one byte |
| qStatus | output | 2 | Queue operation of the previous cycle |
| memReq | output | 1 | Fetch request |
| memAddr | output | 20 | Physical fetch address (all ones when idle) |
| memHighEnN | output | 1 | Active-low upper byte lane enable |
| memSegStat | output | 2 | Segment in use: 10 during code fetch, 00 idle |
| memAck | input | 1 | Memory accepts the request; data valid this cycle |
| memRdata | input | 16 | Read data, low lane = even byte |

## Verification
The bench walks the offset across odd starting points and across the 16-bit offset wrap. It also uses a segment large enough that the shifted sum wraps at 2^20. A design that misplaces the odd byte, increments by 2 from an odd offset, or carries into a 21st bit returns a byte stream that does not match the addressed memory image. Flushes are made to coincide with a take and with a memory acknowledge. A design that lets the take through, or that keeps the stale response, shows a non-empty queue or a wrong status code after the flush. Takes on an empty queue and a queue left to fill completely check that status stays 00 and that no request is raised once fewer than two slots are free.

// File: rtl/fqu_pkg.sv
`timescale 1ns/1ps
package fqu_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic flush;     // clear queue, load new segment:offset
    logic pop;       // remove head byte
    logic push;      // accepted memory response enters the queue
    logic pushWord;  // response carries two bytes (even address)
  } fquStrobe_t;

  // Per-cycle queue operation codes
  typedef enum logic [1:0] {
    QS_NONE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qStat_e;

  localparam logic [1:0] SEG_CODE = 2'b10;
  localparam logic [1:0] SEG_NONE = 2'b00;
  localparam int         LANE_W   = 8;
  localparam int         SEG_SHIFT = 4;

endpackage

// File: rtl/fqu_ctrl.sv
`timescale 1ns/1ps
module fqu_ctrl
  import fqu_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushReq,
  input  logic             takeReq,
  input  logic             takeFirst,
  input  logic             memAck,
  input  logic [CNT_W-1:0] count,
  input  logic             ipOdd,
  output fquStrobe_t       strb,
  output logic             memReq,
  output logic             memHighEnN,
  output logic [1:0]       memSegStat,
  output logic             qValid,
  output logic [1:0]       qStatus
);

  localparam logic [CNT_W-1:0] FULL_LEVEL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] freeSlots;
  logic [CNT_W-1:0] needSlots;
  logic             takeOk;
  qStat_e           statusD;
  qStat_e           statusQ;

  // Space check: odd fetch brings one byte, word fetch brings two
  always_comb begin
    freeSlots = FULL_LEVEL - count;
    needSlots = ipOdd ? CNT_W'(1) : CNT_W'(2);
    memReq    = (freeSlots >= needSlots);
  end

  always_comb begin
    qValid     = (count != '0);
    takeOk     = takeReq && qValid && !flushReq;
    memHighEnN = !memReq;
    memSegStat = memReq ? SEG_CODE : SEG_NONE;
  end

  always_comb begin
    strb          = '0;
    strb.flush    = flushReq;
    strb.pop      = takeOk;
    strb.push     = memReq && memAck && !flushReq;
    strb.pushWord = !ipOdd;
  end

  // Operation code for this cycle, published after the edge
  always_comb begin
    if (flushReq)    statusD = QS_FLUSH;
    else if (takeOk) statusD = takeFirst ? QS_FIRST : QS_NEXT;
    else             statusD = QS_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= QS_NONE;
    else       statusQ <= statusD;
  end

  assign qStatus = statusQ;

endmodule

// File: rtl/fqu_datapath.sv
`timescale 1ns/1ps
module fqu_datapath
  import fqu_pkg::*;
#(
  parameter int                DEPTH     = 6,
  parameter int                SEG_W     = 16,
  parameter int                OFF_W     = 16,
  parameter logic [SEG_W-1:0]  RESET_SEG = '1,
  parameter logic [OFF_W-1:0]  RESET_OFF = '0,
  parameter int                ADDR_W    = SEG_W + SEG_SHIFT,
  parameter int                CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fquStrobe_t        strb,
  input  logic [SEG_W-1:0]  flushSeg,
  input  logic [OFF_W-1:0]  flushOff,
  input  logic              memReq,
  input  logic [2*LANE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANE_W-1:0] qByte,
  output logic [CNT_W-1:0]  count,
  output logic              ipOdd
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [SEG_W-1:0]  segQ;
  logic [OFF_W-1:0]  ipQ;
  logic [PTR_W-1:0]  rdPtr, wrPtr, wrNext, wrAfter;
  logic [DEPTH-1:0][LANE_W-1:0] qMem;
  logic [DEPTH-1:0]  wrEn;
  logic [DEPTH-1:0][LANE_W-1:0] wrData;
  logic [LANE_W-1:0] leadByte;
  logic [CNT_W-1:0]  pushCnt, popCnt;
  logic [ADDR_W-1:0] physAddr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // Physical address: segment shifted by four plus offset
  always_comb begin
    physAddr = {segQ, {SEG_SHIFT{1'b0}}} + ADDR_W'(ipQ);
    memAddr  = memReq ? physAddr : '1;
    ipOdd    = ipQ[0];
  end

  // Lane selection: odd fetch keeps only the upper lane
  always_comb begin
    leadByte = strb.pushWord ? memRdata[LANE_W-1:0] : memRdata[2*LANE_W-1:LANE_W];
    wrNext   = bump(wrPtr);
    wrAfter  = strb.pushWord ? bump(wrNext) : wrNext;
    pushCnt  = strb.push ? (strb.pushWord ? CNT_W'(2) : CNT_W'(1)) : '0;
    popCnt   = strb.pop ? CNT_W'(1) : '0;
  end

  // Per-slot write enables and data
  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_comb begin
      wrEn[i]   = 1'b0;
      wrData[i] = leadByte;
      if (strb.push && (wrPtr == PTR_W'(i))) begin
        wrEn[i]   = 1'b1;
        wrData[i] = leadByte;
      end else if (strb.push && strb.pushWord && (wrNext == PTR_W'(i))) begin
        wrEn[i]   = 1'b1;
        wrData[i] = memRdata[2*LANE_W-1:LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qMem <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (wrEn[k]) qMem[k] <= wrData[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strb.pop)  rdPtr <= bump(rdPtr);
      if (strb.push) wrPtr <= wrAfter;
      count <= count + pushCnt - popCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segQ <= RESET_SEG;
      ipQ  <= RESET_OFF;
    end else if (strb.flush) begin
      segQ <= flushSeg;
      ipQ  <= flushOff;
    end else if (strb.push) begin
      ipQ  <= ipQ + (strb.pushWord ? OFF_W'(2) : OFF_W'(1));
    end
  end

  assign qByte = qMem[rdPtr];

endmodule

// File: rtl/fetch_queue_unit.sv
`timescale 1ns/1ps
module fetch_queue_unit
  import fqu_pkg::*;
#(
  parameter int               DEPTH     = 6,
  parameter int               SEG_W     = 16,
  parameter int               OFF_W     = 16,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushReq,
  input  logic [SEG_W-1:0] flushSeg,
  input  logic [OFF_W-1:0] flushOff,
  input  logic             takeReq,
  input  logic             takeFirst,
  output logic [7:0]       qByte,
  output logic             qValid,
  output logic [1:0]       qStatus,
  output logic             memReq,
  output logic [SEG_W+3:0] memAddr,
  output logic             memHighEnN,
  output logic [1:0]       memSegStat,
  input  logic             memAck,
  input  logic [15:0]      memRdata
);

  localparam int ADDR_W = SEG_W + SEG_SHIFT;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  fquStrobe_t       strb;
  logic [CNT_W-1:0] qCount;
  logic             ipOdd;

  fqu_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flushReq   (flushReq),
    .takeReq    (takeReq),
    .takeFirst  (takeFirst),
    .memAck     (memAck),
    .count      (qCount),
    .ipOdd      (ipOdd),
    .strb       (strb),
    .memReq     (memReq),
    .memHighEnN (memHighEnN),
    .memSegStat (memSegStat),
    .qValid     (qValid),
    .qStatus    (qStatus)
  );

  fqu_datapath #(
    .DEPTH(DEPTH), .SEG_W(SEG_W), .OFF_W(OFF_W),
    .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .flushSeg (flushSeg),
    .flushOff (flushOff),
    .memReq   (memReq),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .qByte    (qByte),
    .count    (qCount),
    .ipOdd    (ipOdd)
  );

endmodule

// File: rtl/fqu_checker.sv
`timescale 1ns/1ps
module fqu_checker #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushReq,
  input logic              takeReq,
  input logic              qValid,
  input logic [1:0]        qStatus,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memHighEnN,
  input logic [1:0]        memSegStat,
  input logic [CNT_W-1:0]  qCount
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(DEPTH)); // R4

  AST_IDLE_LANES: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |-> (memHighEnN && memAddr[0])); // R3

  AST_NO_LOW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !memHighEnN); // R3

  AST_FLUSH_CODE: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (qStatus == 2'b10)); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !qValid); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !flushReq) |=> (memReq && $stable(memAddr))); // R12

  AST_SEG_CODE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memSegStat == 2'b10)); // R10

  AST_EMPTY_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && !qValid && !flushReq) |=> (qStatus == 2'b00)); // R11

endmodule

bind fetch_queue_unit fqu_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .flushReq   (flushReq),
  .takeReq    (takeReq),
  .qValid     (qValid),
  .qStatus    (qStatus),
  .memReq     (memReq),
  .memAck     (memAck),
  .memAddr    (memAddr),
  .memHighEnN (memHighEnN),
  .memSegStat (memSegStat),
  .qCount     (qCount)
);

// File: tb/sim_fetch_queue_unit.sv
`timescale 1ns/1ps
module sim_fetch_queue_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushReq = 1'b0;
  logic [15:0] flushSeg = '0;
  logic [15:0] flushOff = '0;
  logic        takeReq = 1'b0;
  logic        takeFirst = 1'b0;
  logic [7:0]  qByte;
  logic        qValid;
  logic [1:0]  qStatus;
  logic        memReq;
  logic [19:0] memAddr;
  logic        memHighEnN;
  logic [1:0]  memSegStat;
  logic        memAck = 1'b0;
  logic [15:0] memRdata = '0;

  int testsRun = 0;
  int testsFailed = 0;
  int ackDelay = 1;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_queue_unit u0 (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .flushSeg(flushSeg),
    .flushOff(flushOff), .takeReq(takeReq), .takeFirst(takeFirst),
    .qByte(qByte), .qValid(qValid), .qStatus(qStatus), .memReq(memReq),
    .memAddr(memAddr), .memHighEnN(memHighEnN), .memSegStat(memSegStat),
    .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [19:0] physOf(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [7:0] memByte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference stream position for the consumer side
  logic [15:0] refSeg = 16'hFFFF, refOff = 16'h0000;
  logic [7:0]  expQ[$];

  // Driver: one cycle of stimulus, pushes the expected byte when a take is accepted
  task automatic step(input bit fl, input logic [15:0] s, input logic [15:0] o,
                      input bit tk, input bit first);
    @(negedge clk);
    flushReq = fl; flushSeg = s; flushOff = o;
    takeReq = tk; takeFirst = first;
    if (fl) begin
      refSeg = s; refOff = o;
    end else if (tk && qValid) begin
      expQ.push_back(memByte(physOf(refSeg, refOff)));
      refOff = refOff + 16'd1;
    end
  endtask

  task automatic idle(); step(0, 16'h0, 16'h0, 0, 0); endtask
  task automatic take(input bit first); step(0, 16'h0, 16'h0, 1, first); endtask
  task automatic jump(input logic [15:0] s, input logic [15:0] o); step(1, s, o, 0, 0); endtask

  // Memory model and fetch-address tracking
  logic [15:0] fSeg = 16'hFFFF, fOff = 16'h0000;
  int waitCnt = 0;
  always begin
    @(negedge clk);
    #0.5;
    memAck = 1'b0;
    if (!rstN) begin
      fSeg = 16'hFFFF; fOff = 16'h0000; waitCnt = 0;
    end else begin
      if (memReq) begin
        chk("R2 R5 R12 fetch address", 32'(memAddr), 32'(physOf(fSeg, fOff)));
        chk("R3 lane code", {30'h0, memHighEnN, memAddr[0]}, {30'h0, 1'b0, fOff[0]});
        chk("R10 segment code", 32'(memSegStat), 32'h2);
        if (waitCnt >= ackDelay) begin
          logic [19:0] al;
          al = {memAddr[19:1], 1'b0};
          memAck = 1'b1;
          memRdata = {memByte(al | 20'h1), memByte(al)};
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end else begin
        chk("R3 idle lanes", {30'h0, memHighEnN, memAddr[0]}, 32'h3);
      end
      if (flushReq) begin
        fSeg = flushSeg; fOff = flushOff; waitCnt = 0;
      end else if (memAck) begin
        fOff = fOff + (fOff[0] ? 16'd1 : 16'd2);
      end
    end
  end

  // Monitor: byte scoreboard and status codes
  logic [1:0] expStat;
  bit monOn = 0;
  always begin
    @(negedge clk);
    #1;
    if (!rstN) begin
      monOn = 0;
    end else begin
      if (monOn) chk("R7 R8 R11 queue status", 32'(qStatus), 32'(expStat));
      if (flushReq)                expStat = 2'b10;
      else if (takeReq && qValid)  expStat = takeFirst ? 2'b01 : 2'b11;
      else                         expStat = 2'b00;
      monOn = 1;
      if (takeReq && qValid && !flushReq) begin
        if (expQ.size() == 0) chk("R6 scoreboard underrun", 32'h1, 32'h0);
        else chk("R6 byte order", 32'(qByte), 32'(expQ.pop_front()));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nextRand(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1 reset state
    chk("R1 qValid after reset", 32'(qValid), 32'h0);
    chk("R1 qStatus after reset", 32'(qStatus), 32'h0);
    chk("R1 first fetch address", 32'(memAddr), 32'hFFFF0);
    chk("R1 first fetch is word", 32'(memHighEnN), 32'h0);

    // R4 fill without consuming: request drops when full
    repeat (15) idle();
    #2;
    chk("R4 no request when full", 32'(memReq), 32'h0);
    chk("R4 queue valid", 32'(qValid), 32'h1);

    // R6 R7 drain in order with first/next marks
    take(1); take(0); take(0); take(1); take(0); take(0);
    repeat (8) idle();

    // R3 R5 odd start then even continuation
    jump(16'h1234, 16'h0011);
    repeat (6) idle();
    take(1); take(0); take(0); take(0); take(0);
    idle();

    // R5 offset wraps within 16 bits
    jump(16'hF000, 16'hFFFD);
    repeat (8) idle();
    for (int i = 0; i < 6; i++) take(i == 0);
    repeat (4) idle();
    for (int i = 0; i < 4; i++) take(0);

    // R2 physical address wraps at 20 bits
    jump(16'hFFFF, 16'hFFF8);
    repeat (8) idle();
    for (int i = 0; i < 6; i++) take(0);
    idle();

    // R8 R11 flush, then take on empty queue
    jump(16'h0100, 16'h0020);
    take(1);
    #2;
    chk("R8 flush code", 32'(qStatus), 32'h2);
    chk("R8 queue empty after flush", 32'(qValid), 32'h0);
    idle();
    #2;
    chk("R11 take on empty ignored", 32'(qStatus), 32'h0);

    // R8 flush wins over a take in the same cycle
    repeat (10) idle();
    step(1, 16'h2000, 16'h0007, 1, 1);
    idle();
    #2;
    chk("R8 flush beats take", 32'(qStatus), 32'h2);
    chk("R8 queue empty", 32'(qValid), 32'h0);
    for (int i = 0; i < 4; i++) take(i == 0);

    // R9 acknowledge in the flush cycle is discarded
    ackDelay = 0;
    jump(16'h3000, 16'h0040);
    jump(16'h4000, 16'h0081);
    idle();
    #2;
    chk("R9 stale response dropped", 32'(qValid), 32'h0);
    repeat (4) idle();
    for (int i = 0; i < 5; i++) take(i == 0);

    // Mixed traffic
    for (int c = 0; c < 3000; c++) begin
      lfsr = nextRand(lfsr);
      ackDelay = int'(lfsr[9:8]) % 3;
      if (lfsr[3:0] == 4'h0) begin
        logic [15:0] s, o;
        lfsr = nextRand(lfsr); s = lfsr;
        lfsr = nextRand(lfsr); o = lfsr;
        jump(s, o);
      end else begin
        step(0, 16'h0, 16'h0, lfsr[5], lfsr[7:6] == 2'b00);
      end
    end
    repeat (4) idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule